// File: doc/BRIEF.md
# Shared-Memory Bus Slot Sequencer

This block produces the fixed time-division schedule by which a CPU and a video fetch unit share a single 16-bit RAM. It runs from a 32 MHz clock. It divides that clock by four to get an 8 MHz slot enable, which is a one-clock pulse. Four consecutive slots form one system cycle of 500 ns, so there are 2 million system cycles per second. On each slot pulse the block gives the slot to the video requester, to the CPU requester, or to nobody. The wheel never waits for requests: ownership depends only on the slot position and the allocation mode.

In normal mode, slot 0 goes to video and slot 1 goes to the CPU. Slots 2 and 3 stay idle. In turbo mode, slot 2 also goes to the CPU, which gives the CPU twice the bandwidth. The block samples the mode at the start of each system cycle, so a cycle never mixes the two allocations. Peripherals can lock onto the schedule through the slot index output and the cycle-start pulse.

Top module: `bus_slot_sequencer`

## Requirements
- R1: `slot_en_o` is high for exactly one clock in every 4 clocks, which turns the 32 MHz clock into an 8 MHz enable.
- R2: `slot_idx_o` is a binary slot number. On each `slot_en_o` pulse it shows the slot that just started, in the order 0, 1, 2, 3, 0, ... One system cycle is 4 slots, or 16 clocks.
- R3: In slot 0, `grant_video_o` is asserted and `grant_cpu_o` is not, in both modes.
- R4: In slot 1, `grant_cpu_o` is asserted and `grant_video_o` is not, in both modes.
- R5: In slot 2, `grant_cpu_o` is asserted when the cycle runs in turbo mode (`turbo_i` = 1). It stays low in normal mode. `grant_video_o` is low in slot 2 in both modes.
- R6: In slot 3, neither grant is asserted.
- R7: A grant is only high together with `slot_en_o`, and the two grants are never high at the same time.
- R8: `cycle_start_o` is high exactly on the slot enable pulses that carry slot index 0.
- R9: `turbo_i` is sampled on the clock edge that issues the slot-0 strobe. Changes of `turbo_i` at any other time have no effect until the next system cycle.
- R10: While `rst` is high, all strobes are low. After `rst` falls, the first strobe comes on the 4th rising edge. That strobe is slot 0, with video granted and `cycle_start_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 MHz input clock |
| rst | input | 1 | Synchronous active-high reset |
| turbo_i | input | 1 | Allocation mode: 1 gives slot 2 to the CPU |
| slot_en_o | output | 1 | 8 MHz slot enable pulse, one clock wide |
| slot_idx_o | output | 2 | Index of the slot that just started |
| cycle_start_o | output | 1 | Start-of-system-cycle pulse |
| grant_video_o | output | 1 | Video fetch owns the current slot |
| grant_cpu_o | output | 1 | CPU owns the current slot |

## Verification
The bench targets mode changes that happen in the middle of a cycle. It raises `turbo_i` just after a slot-0 strobe and lowers it just before slot 2. A design that reads the mode live instead of latching it would grant slot 2 wrongly in both of these cases. The bench also asserts reset in the middle of a slot and counts the edges to the first strobe after release. A prescaler or wheel that is not cleared would give a shifted phase or a non-zero first index. Every non-strobe clock is checked to be quiet, which catches grants that stay high longer than one pulse.

// File: rtl/bss_pkg.sv
package bss_pkg;

    localparam int unsigned BSS_CLK_PER_SLOT   = 4;
    localparam int unsigned BSS_SLOTS_PER_CYC  = 4;
    localparam int unsigned BSS_VIDEO_SLOT     = 0;
    localparam int unsigned BSS_CPU_SLOT       = 1;
    localparam int unsigned BSS_TURBO_SLOT     = 2;

    typedef enum logic [1:0] {
        OWN_IDLE  = 2'd0,
        OWN_VIDEO = 2'd1,
        OWN_CPU   = 2'd2
    } owner_e;

    typedef struct packed {
        logic en;
        logic start;
        logic video;
        logic cpu;
    } strobe_t;

    function automatic owner_e slot_owner(
        input int unsigned slot,
        input logic        turbo,
        input int unsigned video_slot,
        input int unsigned cpu_slot,
        input int unsigned turbo_slot
    );
        if (slot == video_slot)
            return OWN_VIDEO;
        if (slot == cpu_slot)
            return OWN_CPU;
        if (turbo && slot == turbo_slot)
            return OWN_CPU;
        return OWN_IDLE;
    endfunction

endpackage

// File: rtl/bss_prescaler.sv
module bss_prescaler #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/bss_slot_wheel.sv
module bss_slot_wheel #(
    parameter int unsigned SLOTS = 4,
    parameter int unsigned IW    = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    output logic [IW-1:0] slot_idx
);
    localparam logic [IW-1:0] LAST = IW'(SLOTS - 1);

    always_ff @(posedge clk) begin
        if (rst)
            slot_idx <= '0;
        else if (tick)
            slot_idx <= (slot_idx == LAST) ? '0 : slot_idx + 1'b1;
    end
endmodule

// File: rtl/bss_strobe_gen.sv
module bss_strobe_gen
    import bss_pkg::*;
#(
    parameter int unsigned IW         = 2,
    parameter int unsigned VIDEO_SLOT = 0,
    parameter int unsigned CPU_SLOT   = 1,
    parameter int unsigned TURBO_SLOT = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [IW-1:0] slot_idx,
    input  logic          turbo_req,
    output strobe_t       strobe_q,
    output logic [IW-1:0] idx_q
);
    logic   mode_q;
    logic   cyc_first;
    logic   cur_mode;
    owner_e own;

    assign cyc_first = (slot_idx == '0);
    // the mode in force is fixed when the cycle opens and held to its end
    assign cur_mode  = cyc_first ? turbo_req : mode_q;
    assign own       = slot_owner(32'(slot_idx), cur_mode, VIDEO_SLOT, CPU_SLOT, TURBO_SLOT);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= 1'b0;
            strobe_q <= '0;
            idx_q    <= '0;
        end else begin
            strobe_q <= '0;
            if (tick) begin
                strobe_q.en    <= 1'b1;
                strobe_q.start <= cyc_first;
                strobe_q.video <= (own == OWN_VIDEO);
                strobe_q.cpu   <= (own == OWN_CPU);
                idx_q          <= slot_idx;
                if (cyc_first)
                    mode_q <= turbo_req;
            end
        end
    end
endmodule

// File: rtl/bus_slot_sequencer.sv
module bus_slot_sequencer
    import bss_pkg::*;
#(
    parameter int unsigned DIV        = BSS_CLK_PER_SLOT,
    parameter int unsigned SLOTS      = BSS_SLOTS_PER_CYC,
    parameter int unsigned VIDEO_SLOT = BSS_VIDEO_SLOT,
    parameter int unsigned CPU_SLOT   = BSS_CPU_SLOT,
    parameter int unsigned TURBO_SLOT = BSS_TURBO_SLOT
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       turbo_i,
    output logic       slot_en_o,
    output logic [1:0] slot_idx_o,
    output logic       cycle_start_o,
    output logic       grant_video_o,
    output logic       grant_cpu_o
);
    localparam int unsigned IW = $clog2(SLOTS);

    logic          tick;
    logic [IW-1:0] wheel_idx;
    logic [IW-1:0] out_idx;
    strobe_t       stb;

    bss_prescaler #(.DIV(DIV)) presc_i (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    bss_slot_wheel #(.SLOTS(SLOTS), .IW(IW)) wheel_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .slot_idx (wheel_idx)
    );

    bss_strobe_gen #(
        .IW(IW), .VIDEO_SLOT(VIDEO_SLOT), .CPU_SLOT(CPU_SLOT), .TURBO_SLOT(TURBO_SLOT)
    ) strobe_i (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .slot_idx  (wheel_idx),
        .turbo_req (turbo_i),
        .strobe_q  (stb),
        .idx_q     (out_idx)
    );

    assign slot_en_o     = stb.en;
    assign cycle_start_o = stb.start;
    assign grant_video_o = stb.video;
    assign grant_cpu_o   = stb.cpu;
    assign slot_idx_o    = 2'(out_idx);
endmodule

// File: rtl/bus_slot_sequencer_chk.sv
module bus_slot_sequencer_chk #(
    parameter int unsigned DIV = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       turbo_i,
    input logic       slot_en_o,
    input logic [1:0] slot_idx_o,
    input logic       cycle_start_o,
    input logic       grant_video_o,
    input logic       grant_cpu_o
);
    localparam int unsigned CW = $clog2(DIV + 1) + 1;

    logic [CW-1:0] gap_q;
    logic [1:0]    last_idx_q;
    logic          seen_q;
    logic          turbo_prev_q;
    logic          cyc_mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q        <= '0;
            last_idx_q   <= '0;
            seen_q       <= 1'b0;
            turbo_prev_q <= 1'b0;
            cyc_mode_q   <= 1'b0;
        end else begin
            turbo_prev_q <= turbo_i;
            if (slot_en_o) begin
                gap_q      <= CW'(1);
                last_idx_q <= slot_idx_o;
                seen_q     <= 1'b1;
                if (slot_idx_o == 2'd0)
                    cyc_mode_q <= turbo_prev_q;
            end else if (gap_q <= CW'(DIV)) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    p_en_period_r1: assert property (@(posedge clk) disable iff (rst)
        slot_en_o |-> gap_q == CW'(DIV));
    p_no_early_en_r1: assert property (@(posedge clk) disable iff (rst)
        gap_q < CW'(DIV) |-> !slot_en_o);
    p_idx_step_r2: assert property (@(posedge clk) disable iff (rst)
        (slot_en_o && seen_q) |-> slot_idx_o == last_idx_q + 2'd1);
    p_video_slot0_r3: assert property (@(posedge clk) disable iff (rst)
        grant_video_o |-> slot_idx_o == 2'd0);
    p_slot1_cpu_r4: assert property (@(posedge clk) disable iff (rst)
        (slot_en_o && slot_idx_o == 2'd1) |-> grant_cpu_o);
    p_turbo_slot2_r5: assert property (@(posedge clk) disable iff (rst)
        (slot_en_o && slot_idx_o == 2'd2) |-> grant_cpu_o == cyc_mode_q);
    p_slot3_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (slot_en_o && slot_idx_o == 2'd3) |-> !grant_cpu_o && !grant_video_o);
    p_grant_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        (grant_video_o || grant_cpu_o) |-> slot_en_o && !(grant_video_o && grant_cpu_o));
    p_cstart_r8: assert property (@(posedge clk) disable iff (rst)
        cycle_start_o == (slot_en_o && slot_idx_o == 2'd0));
    p_reset_quiet_r10: assert property (@(posedge clk)
        rst |=> !slot_en_o && !grant_video_o && !grant_cpu_o && !cycle_start_o);
endmodule

bind bus_slot_sequencer bus_slot_sequencer_chk #(.DIV(DIV)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .turbo_i       (turbo_i),
    .slot_en_o     (slot_en_o),
    .slot_idx_o    (slot_idx_o),
    .cycle_start_o (cycle_start_o),
    .grant_video_o (grant_video_o),
    .grant_cpu_o   (grant_cpu_o)
);

// File: tb/bus_slot_sequencer_tb_top.sv
module bus_slot_sequencer_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       turbo_i = 1'b0;
    logic       slot_en_o;
    logic [1:0] slot_idx_o;
    logic       cycle_start_o;
    logic       grant_video_o;
    logic       grant_cpu_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    bus_slot_sequencer dut_i (
        .clk(clk), .rst(rst), .turbo_i(turbo_i),
        .slot_en_o(slot_en_o), .slot_idx_o(slot_idx_o),
        .cycle_start_o(cycle_start_o),
        .grant_video_o(grant_video_o), .grant_cpu_o(grant_cpu_o)
    );

    // row bits: {turbo, idx[1:0], video, cpu, cycle_start}
    localparam int NROW = 16;
    localparam logic [5:0] VEC [NROW] = '{
        6'b000101, 6'b001010, 6'b010000, 6'b011000,   // normal cycle
        6'b100101, 6'b101010, 6'b110010, 6'b111000,   // turbo cycle
        6'b100101, 6'b001010, 6'b010010, 6'b011000,   // turbo dropped mid-cycle
        6'b000101, 6'b101010, 6'b110000, 6'b111000    // turbo raised mid-cycle
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] outs();
        return {slot_idx_o, grant_video_o, grant_cpu_o, cycle_start_o};
    endfunction

    // waits for one slot: 3 quiet clocks, then the strobe clock
    task automatic one_slot(input string req, input logic [4:0] exp);
        bit quiet = 1'b1;
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            if (slot_en_o || grant_video_o || grant_cpu_o || cycle_start_o)
                quiet = 1'b0;
        end
        chk("R1/R7 quiet between strobes", 32'(quiet), 32'd1);
        @(negedge clk);
        chk("R1 slot_en pulse", 32'(slot_en_o), 32'd1);
        chk(req, 32'(outs()), 32'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset quiet", {28'd0, slot_en_o, grant_video_o, grant_cpu_o, cycle_start_o}, 32'd0);
        rst = 1'b0;
        for (int r = 0; r < NROW; r++) begin
            turbo_i = VEC[r][5];
            case (VEC[r][4:3])
                2'd0: one_slot("R3/R8/R10 slot0 video", VEC[r][4:0]);
                2'd1: one_slot("R4 slot1 cpu", VEC[r][4:0]);
                2'd2: one_slot("R5/R9 slot2 mode", VEC[r][4:0]);
                default: one_slot("R6/R2 slot3 idle", VEC[r][4:0]);
            endcase
        end
        // R9: full turbo cycle with turbo held high
        turbo_i = 1'b1;
        one_slot("R9 slot0", 5'b00101);
        one_slot("R4 slot1", 5'b01010);
        one_slot("R5 turbo slot2", 5'b10010);
        one_slot("R6 slot3", 5'b11000);
        // R10: reset in the middle of a slot
        repeat (2) @(negedge clk);
        rst = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R10 quiet in reset", {28'd0, slot_en_o, grant_video_o, grant_cpu_o, cycle_start_o}, 32'd0);
        end
        turbo_i = 1'b0;
        rst = 1'b0;
        one_slot("R10 first strobe after reset", 5'b00101);
        one_slot("R2 index after reset", 5'b01010);
        one_slot("R5 normal slot2 after reset", 5'b10000);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule